// File: doc/BRIEF.md
# Multichannel DMA Command-Port Register File

This block is the programming front end of a sixteen-channel bus DMA controller. Software reaches every channel through two byte-wide ports. A command byte names an operation and a channel. The data port then moves the bytes that belong to that operation, and an internal byte pointer steps forward after each accepted byte. Each channel holds a 16-bit I/O port number, a 24-bit memory address, a 16-bit unit count (stored as units minus one) and a mode byte. Each channel also has a mask bit that disables it.

The transfer engine sits beside this block. It picks a channel with `eng_sel` and sees that channel's registers and decoded mode flags on the `eng_*` outputs. It also sees the mask bits of all channels. Read-back commands copy the address or count into a snapshot when the command is written. The bytes that follow on the data port therefore all come from one value. The status, arbitration and master-clear commands do nothing here.

Top module: `dma_cmd_regfile`

## Requirements
- R1: After reset, every channel is masked (`chan_mask` all ones), every channel register reads zero on the engine view, and `dat_rdata` is zero. Data-port activity before the first command changes nothing.
- R2: A command byte carries the opcode in bits 7:4 and the channel in bits 3:0. Opcode 0x9 sets the channel's mask bit and opcode 0xA clears it, taking effect on the clock edge that accepts the command.
- R3: After opcode 0x0, two data writes load the channel's 16-bit I/O port, low byte first.
- R4: After opcode 0x2, three data writes load the 24-bit address: bits 7:0, then 15:8, then 23:16.
- R5: After opcode 0x4, two data writes load the 16-bit count, low byte first. The count is stored exactly as written (units minus one), so 0xFFFF stands for 65536 units.
- R6: After opcode 0x7, one data write loads the mode byte. On the engine view, bit 2 drives `eng_start`, bit 3 drives `eng_read` (clear means write), bit 0 drives `eng_io` and bit 6 drives `eng_wide` (16-bit units).
- R7: Every command write resets the byte pointer to zero. Data writes beyond the number of bytes the current load opcode expects are ignored.
- R8: Opcode 0x3 (address) or 0x5 (count) latches the channel's value when the command is written. `dat_rdata` then shows the byte at the pointer, lowest byte first, and each `dat_re` advances the pointer. Once every byte has been read, and whenever the current command is not a read-back, `dat_rdata` is zero.
- R9: Other opcodes (for example 0x1, 0x6, 0x8, 0xD) change no channel register and no mask bit. Data writes after them, and data writes during a read-back command, are ignored.
- R10: Register loads are accepted while a channel is masked. A command write in the same cycle as a data write takes priority, and that data byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command port write strobe |
| cmd_byte | input | 8 | Command byte: opcode 7:4, channel 3:0 |
| dat_we | input | 1 | Data port write strobe |
| dat_wbyte | input | 8 | Data port write byte |
| dat_re | input | 1 | Data port read strobe, advances the pointer |
| dat_rdata | output | 8 | Read-back byte at the current pointer |
| eng_sel | input | 4 | Channel shown on the engine view |
| eng_ioport | output | 16 | I/O port of the selected channel |
| eng_addr | output | 24 | Address of the selected channel |
| eng_count | output | 16 | Count (units minus one) of the selected channel |
| eng_mode | output | 8 | Raw mode byte of the selected channel |
| eng_start | output | 1 | Mode bit 2 of the selected channel |
| eng_read | output | 1 | Mode bit 3 of the selected channel |
| eng_io | output | 1 | Mode bit 0 of the selected channel |
| eng_wide | output | 1 | Mode bit 6 of the selected channel |
| chan_mask | output | 16 | Mask bit of every channel, 1 = disabled |

## Verification
A byte pointer that goes wrong puts a byte into the wrong lane of a register. This shows on the engine view in the cycle after the data write, as long as the bench watches that channel. A stale or mis-latched snapshot shows on `dat_rdata` right after the command, before any `dat_re`. A wrong mask bit shows on `chan_mask` one edge after the command. Because the reference model is compared on every clock while `eng_sel` moves through the channels, a corrupted register on a channel the bench is not watching is caught as soon as the selector reaches it.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    // Opcodes carried in bits 7:4 of a command byte
    localparam logic [3:0] OPC_PORT_LD  = 4'h0;
    localparam logic [3:0] OPC_ADDR_LD  = 4'h2;
    localparam logic [3:0] OPC_ADDR_RB  = 4'h3;
    localparam logic [3:0] OPC_CNT_LD   = 4'h4;
    localparam logic [3:0] OPC_CNT_RB   = 4'h5;
    localparam logic [3:0] OPC_MODE_LD  = 4'h7;
    localparam logic [3:0] OPC_DISABLE  = 4'h9;
    localparam logic [3:0] OPC_ENABLE   = 4'hA;

    // Bit positions inside the mode byte
    localparam int MB_IO    = 0;
    localparam int MB_START = 2;
    localparam int MB_READ  = 3;
    localparam int MB_WIDE  = 6;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_PORT,
        FLD_ADDR,
        FLD_CNT,
        FLD_MODE
    } field_e;

    typedef struct packed {
        logic       load;      // data writes fill a register
        logic       rdbk;      // data reads drain a snapshot
        logic       set_mask;
        logic       clr_mask;
        field_e     fld;
        logic [2:0] nbytes;    // bytes the opcode moves
    } dec_t;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_cmd_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 8
) (
    input  logic [3:0] opc,
    output dec_t       dec
);
    localparam logic [2:0] NB_PORT = 3'(PORT_W / 8);
    localparam logic [2:0] NB_ADDR = 3'(ADDR_W / 8);
    localparam logic [2:0] NB_CNT  = 3'(CNT_W / 8);
    localparam logic [2:0] NB_MODE = 3'(MODE_W / 8);

    always_comb begin
        dec = '{load: 1'b0, rdbk: 1'b0, set_mask: 1'b0, clr_mask: 1'b0,
                fld: FLD_NONE, nbytes: 3'd0};
        case (opc)
            OPC_PORT_LD: begin dec.load = 1'b1; dec.fld = FLD_PORT; dec.nbytes = NB_PORT; end
            OPC_ADDR_LD: begin dec.load = 1'b1; dec.fld = FLD_ADDR; dec.nbytes = NB_ADDR; end
            OPC_ADDR_RB: begin dec.rdbk = 1'b1; dec.fld = FLD_ADDR; dec.nbytes = NB_ADDR; end
            OPC_CNT_LD:  begin dec.load = 1'b1; dec.fld = FLD_CNT;  dec.nbytes = NB_CNT;  end
            OPC_CNT_RB:  begin dec.rdbk = 1'b1; dec.fld = FLD_CNT;  dec.nbytes = NB_CNT;  end
            OPC_MODE_LD: begin dec.load = 1'b1; dec.fld = FLD_MODE; dec.nbytes = NB_MODE; end
            OPC_DISABLE: dec.set_mask = 1'b1;
            OPC_ENABLE:  dec.clr_mask = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_cmd_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int PORT_W = 16,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  field_e            wr_fld,
    input  logic [2:0]        wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic [CH_W-1:0]   src_ch,
    output logic [ADDR_W-1:0] src_addr,
    output logic [CNT_W-1:0]  src_cnt,
    input  logic [CH_W-1:0]   view_ch,
    output logic [PORT_W-1:0] view_port,
    output logic [ADDR_W-1:0] view_addr,
    output logic [CNT_W-1:0]  view_cnt,
    output logic [MODE_W-1:0] view_mode
);
    typedef struct packed {
        logic [PORT_W-1:0] ioport;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [MODE_W-1:0] mode;
    } chan_t;

    chan_t chans_d [NCH];
    chan_t chans_q [NCH];

    logic [5:0] lane;
    assign lane = {wr_idx, 3'b000};

    always_comb begin
        for (int i = 0; i < NCH; i++) chans_d[i] = chans_q[i];
        if (wr_en) begin
            case (wr_fld)
                FLD_PORT: chans_d[wr_ch].ioport[lane +: 8] = wr_byte;
                FLD_ADDR: chans_d[wr_ch].addr[lane +: 8]   = wr_byte;
                FLD_CNT:  chans_d[wr_ch].cnt[lane +: 8]    = wr_byte;
                FLD_MODE: chans_d[wr_ch].mode[lane +: 8]   = wr_byte;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chans_q[g] <= '0;
            else        chans_q[g] <= chans_d[g];
        end
    end

    assign src_addr  = chans_q[src_ch].addr;
    assign src_cnt   = chans_q[src_ch].cnt;
    assign view_port = chans_q[view_ch].ioport;
    assign view_addr = chans_q[view_ch].addr;
    assign view_cnt  = chans_q[view_ch].cnt;
    assign view_mode = chans_q[view_ch].mode;

endmodule

// File: rtl/dma_cmd_regfile.sv
module dma_cmd_regfile
    import dma_cmd_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int PORT_W = 16,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              dat_we,
    input  logic [7:0]        dat_wbyte,
    input  logic              dat_re,
    output logic [7:0]        dat_rdata,
    input  logic [CH_W-1:0]   eng_sel,
    output logic [PORT_W-1:0] eng_ioport,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [CNT_W-1:0]  eng_count,
    output logic [MODE_W-1:0] eng_mode,
    output logic              eng_start,
    output logic              eng_read,
    output logic              eng_io,
    output logic              eng_wide,
    output logic [NCH-1:0]    chan_mask
);
    localparam int SNAP_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;

    typedef struct packed {
        logic              cmd_vld;
        logic [3:0]        opc;
        logic [CH_W-1:0]   ch;
        logic [2:0]        ptr;
        logic [SNAP_W-1:0] snap;
        logic [NCH-1:0]    mask;
    } st_t;

    st_t st_d, st_q;

    dec_t new_dec, cur_dec;
    logic [CH_W-1:0]   new_ch;
    logic [ADDR_W-1:0] src_addr;
    logic [CNT_W-1:0]  src_cnt;
    logic              wr_en;
    logic              in_range;

    assign new_ch = cmd_byte[CH_W-1:0];

    dma_cmd_decode #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W))
        u_dec_new (.opc(cmd_byte[7:4]), .dec(new_dec));

    dma_cmd_decode #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W))
        u_dec_cur (.opc(st_q.opc), .dec(cur_dec));

    dma_chan_bank #(.NCH(NCH), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W))
        u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_ch     (st_q.ch),
            .wr_fld    (cur_dec.fld),
            .wr_idx    (st_q.ptr),
            .wr_byte   (dat_wbyte),
            .src_ch    (new_ch),
            .src_addr  (src_addr),
            .src_cnt   (src_cnt),
            .view_ch   (eng_sel),
            .view_port (eng_ioport),
            .view_addr (eng_addr),
            .view_cnt  (eng_count),
            .view_mode (eng_mode)
        );

    assign in_range = st_q.cmd_vld && (st_q.ptr < cur_dec.nbytes);

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (cmd_we) begin
            st_d.cmd_vld = 1'b1;
            st_d.opc     = cmd_byte[7:4];
            st_d.ch      = new_ch;
            st_d.ptr     = 3'd0;
            if (new_dec.set_mask) st_d.mask[new_ch] = 1'b1;
            if (new_dec.clr_mask) st_d.mask[new_ch] = 1'b0;
            if (new_dec.rdbk)
                st_d.snap = (new_dec.fld == FLD_ADDR) ? SNAP_W'(src_addr) : SNAP_W'(src_cnt);
            else
                st_d.snap = '0;
        end else if (in_range && cur_dec.load && dat_we) begin
            wr_en    = 1'b1;
            st_d.ptr = st_q.ptr + 3'd1;
        end else if (in_range && cur_dec.rdbk && dat_re) begin
            st_d.ptr = st_q.ptr + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dat_rdata = (in_range && cur_dec.rdbk) ? st_q.snap[{st_q.ptr, 3'b000} +: 8] : 8'h00;
    assign chan_mask = st_q.mask;
    assign eng_start = eng_mode[MB_START];
    assign eng_read  = eng_mode[MB_READ];
    assign eng_io    = eng_mode[MB_IO];
    assign eng_wide  = eng_mode[MB_WIDE];

endmodule

// File: rtl/dma_cmd_regfile_chk.sv
module dma_cmd_regfile_chk #(
    parameter int NCH    = 16,
    parameter int PORT_W = 16,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [7:0]        cmd_byte,
    input logic              dat_we,
    input logic [7:0]        dat_rdata,
    input logic [CH_W-1:0]   eng_sel,
    input logic [PORT_W-1:0] eng_ioport,
    input logic [ADDR_W-1:0] eng_addr,
    input logic [CNT_W-1:0]  eng_count,
    input logic [MODE_W-1:0] eng_mode,
    input logic [NCH-1:0]    chan_mask
);
    // R1: first active cycle shows every channel masked and no read data
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (chan_mask == '1 && dat_rdata == 8'h00));

    // R2: disable command sets the addressed mask bit
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] == 4'h9) |=> chan_mask[$past(cmd_byte[CH_W-1:0])]);

    // R2: enable command clears the addressed mask bit
    assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] == 4'hA) |=> !chan_mask[$past(cmd_byte[CH_W-1:0])]);

    // R9: commands other than mask/unmask leave every mask bit alone
    assert_nop_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] != 4'h9 && cmd_byte[7:4] != 4'hA) |=> $stable(chan_mask));

    // R8: after a command that is not a read-back, no read data appears
    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] != 4'h3 && cmd_byte[7:4] != 4'h5) |=> dat_rdata == 8'h00);

    // R9: without a data write, channel registers under a fixed selector hold
    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> (!$stable(eng_sel) ||
                     ($stable(eng_ioport) && $stable(eng_addr) &&
                      $stable(eng_count) && $stable(eng_mode))));

endmodule

bind dma_cmd_regfile dma_cmd_regfile_chk #(
    .NCH(NCH), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .dat_we(dat_we), .dat_rdata(dat_rdata), .eng_sel(eng_sel),
    .eng_ioport(eng_ioport), .eng_addr(eng_addr), .eng_count(eng_count),
    .eng_mode(eng_mode), .chan_mask(chan_mask)
);

// File: tb/dma_cmd_regfile_test.sv
`timescale 1ns/1ps
module dma_cmd_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        dat_we = 1'b0;
    logic [7:0]  dat_wbyte = 8'h00;
    logic        dat_re = 1'b0;
    logic [7:0]  dat_rdata;
    logic [3:0]  eng_sel = 4'd0;
    logic [15:0] eng_ioport;
    logic [23:0] eng_addr;
    logic [15:0] eng_count;
    logic [7:0]  eng_mode;
    logic        eng_start, eng_read, eng_io, eng_wide;
    logic [15:0] chan_mask;

    dma_cmd_regfile uut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    int m_port [16];
    int m_addr [16];
    int m_cnt  [16];
    int m_mode [16];
    bit m_mask [16];
    bit m_vld;
    int m_op, m_ch, m_ptr, m_snap;

    function automatic int nbytes(int op);
        case (op)
            0: return 2;  2: return 3;  3: return 3;
            4: return 2;  5: return 2;  7: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int put_byte(int v, int idx, int b);
        return (v & ~(255 << (8 * idx))) | (b << (8 * idx));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_port[i] = 0; m_addr[i] = 0; m_cnt[i] = 0; m_mode[i] = 0; m_mask[i] = 1'b1;
        end
        m_vld = 1'b0; m_op = 0; m_ch = 0; m_ptr = 0; m_snap = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else if (cmd_we) begin
            m_vld = 1'b1;
            m_op  = int'(cmd_byte[7:4]);
            m_ch  = int'(cmd_byte[3:0]);
            m_ptr = 0;
            if (m_op == 9)  m_mask[m_ch] = 1'b1;
            if (m_op == 10) m_mask[m_ch] = 1'b0;
            m_snap = (m_op == 3) ? m_addr[m_ch] : (m_op == 5) ? m_cnt[m_ch] : 0;
        end else if (m_vld && m_ptr < nbytes(m_op)) begin
            if (dat_we && (m_op == 0 || m_op == 2 || m_op == 4 || m_op == 7)) begin
                case (m_op)
                    0: m_port[m_ch] = put_byte(m_port[m_ch], m_ptr, int'(dat_wbyte));
                    2: m_addr[m_ch] = put_byte(m_addr[m_ch], m_ptr, int'(dat_wbyte));
                    4: m_cnt[m_ch]  = put_byte(m_cnt[m_ch],  m_ptr, int'(dat_wbyte));
                    default: m_mode[m_ch] = int'(dat_wbyte);
                endcase
                m_ptr++;
            end else if (dat_re && (m_op == 3 || m_op == 5)) begin
                m_ptr++;
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // compare every output against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int s, exp_rd, msk;
            s = int'(eng_sel);
            exp_rd = (m_vld && (m_op == 3 || m_op == 5) && m_ptr < nbytes(m_op))
                     ? ((m_snap >> (8 * m_ptr)) & 255) : 0;
            msk = 0;
            for (int i = 0; i < 16; i++) if (m_mask[i]) msk |= (1 << i);
            check("dat_rdata", int'(dat_rdata), exp_rd);
            check("chan_mask", int'(chan_mask), msk);
            check("eng_ioport", int'(eng_ioport), m_port[s]);
            check("eng_addr", int'(eng_addr), m_addr[s]);
            check("eng_count", int'(eng_count), m_cnt[s]);
            check("eng_mode", int'(eng_mode), m_mode[s]);
            check("mode flags R6",
                  int'({eng_wide, eng_read, eng_start, eng_io}),
                  (((m_mode[s] >> 6) & 1) << 3) | (((m_mode[s] >> 3) & 1) << 2) |
                  (((m_mode[s] >> 2) & 1) << 1) | (m_mode[s] & 1));
        end
    end

    task automatic step(bit cw, logic [7:0] cb, bit dw, logic [7:0] db, bit dr);
        @(negedge clk);
        #1;
        cmd_we = cw; cmd_byte = cb; dat_we = dw; dat_wbyte = db; dat_re = dr;
    endtask
    task automatic cmd(logic [7:0] b);  step(1'b1, b, 1'b0, 8'h00, 1'b0); endtask
    task automatic wr(logic [7:0] b);   step(1'b0, 8'h00, 1'b1, b, 1'b0); endtask
    task automatic rd();                step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1); endtask
    task automatic idle();              step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0); endtask

    // explicit read-back sample at the current pointer
    task automatic expect_rd(int exp);
        @(negedge clk);
        check("read-back byte", int'(dat_rdata), exp);
        #1;
        cmd_we = 1'b0; dat_we = 1'b0; dat_re = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";
        wr(8'hAA); wr(8'h55); rd();
        for (int i = 0; i < 16; i++) begin
            eng_sel = 4'(i);
            idle();
        end

        cur_req = "R3"; eng_sel = 4'd5;
        cmd(8'h05); wr(8'h34); wr(8'h12); idle(); idle();

        cur_req = "R4"; eng_sel = 4'd10;
        cmd(8'h2A); wr(8'h11); wr(8'h22); wr(8'h33); idle();

        cur_req = "R5";
        cmd(8'h4A); wr(8'hFF); wr(8'hFF); idle();

        cur_req = "R6";
        cmd(8'h7A); wr(8'h4D); idle();
        cmd(8'h7A); wr(8'h08); idle();

        cur_req = "R7"; eng_sel = 4'd3;
        cmd(8'h03); wr(8'hCD); wr(8'hAB); wr(8'hEE); wr(8'h99); idle();
        cmd(8'h03); wr(8'h01); cmd(8'h03); wr(8'h77); wr(8'h66); idle();

        cur_req = "R8"; eng_sel = 4'd10;
        cmd(8'h3A);
        expect_rd(8'h11); expect_rd(8'h22); expect_rd(8'h33); expect_rd(0);
        cmd(8'h5A);
        expect_rd(8'hFF); expect_rd(8'hFF); expect_rd(0); idle();

        cur_req = "R9";
        cmd(8'h6A); wr(8'h01); wr(8'h02); idle();
        cmd(8'h8A); wr(8'h03); cmd(8'hDA); wr(8'h04); cmd(8'h1A); wr(8'h05);
        cmd(8'h3A); wr(8'h06); wr(8'h07); idle();

        cur_req = "R2"; eng_sel = 4'd3;
        cmd(8'hA3); idle(); cmd(8'hAC); idle(); cmd(8'h93); idle();

        cur_req = "R10";
        cmd(8'h2C); wr(8'h0A); wr(8'h0B); wr(8'h0C); eng_sel = 4'd12; idle();
        cmd(8'h0C); step(1'b1, 8'h0C, 1'b1, 8'h5A, 1'b0); wr(8'h21); wr(8'h43); idle();

        cur_req = "R7 random";
        for (int n = 0; n < 600; n++) begin
            int k, ops [11];
            ops = '{0, 2, 3, 4, 5, 7, 9, 10, 6, 8, 13};
            k = $urandom_range(0, 9);
            eng_sel = 4'($urandom_range(0, 15));
            if (k < 2)
                cmd({4'(ops[$urandom_range(0, 10)]), 4'($urandom_range(0, 15))});
            else if (k < 6) wr(8'($urandom_range(0, 255)));
            else if (k < 8) rd();
            else if (k < 9) step(1'b1, {4'(ops[$urandom_range(0, 10)]), 4'($urandom_range(0, 15))},
                                 1'b1, 8'($urandom_range(0, 255)), 1'b1);
            else idle();
        end
        idle(); idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule